// File: doc/BRIEF.md
# Segment/Page Map Address Translator

This block turns a 32-bit virtual address into a physical address through two on-chip lookup memories, with no page tables in main memory. A segment map, addressed by the current context number and the segment field of the virtual address, yields a page-group number. A page map, addressed by that group number and the page field of the virtual address, yields a 32-bit page entry. The entry supplies the frame number, a non-cacheable flag and the permission bits. The permission bits are checked against the access direction and the privilege mode of the request.

Addresses whose top three bits are neither all zeros nor all ones fall in an unmapped hole. They are rejected at once, without any map lookup. When an access succeeds, the block writes the entry back into the page map with its used bit set, and with its modified bit also set on a write. A faulting access returns a cause code and leaves the map untouched.

Software loads and inspects both maps and the context register through a simple request port. That port is served only while the translator is idle.

The translator is one finite-state machine with four states:
- ST_IDLE: accepts a software access or a translation. A hole address goes straight back to ST_IDLE with a hole response. Any other address goes to ST_SEG.
- ST_SEG: reads the segment map and always moves to ST_PAGE.
- ST_PAGE: reads the page map and always moves to ST_WBACK.
- ST_WBACK: checks the entry, writes it back if the access succeeded, registers the response and always returns to ST_IDLE.

Top module: `segmap_xlate`

## Requirements
- R1: A translation whose va[31:29] is neither 3'b000 nor 3'b111 gets its response in the first cycle after acceptance, with cause 1. Its pa and nc are both 0, and no map is read or written.
- R2: Any other translation keeps req_ready and rsp_valid low for the three cycles after acceptance. rsp_valid then pulses for one cycle in the fourth cycle, and in that cycle the block is idle again.
- R3: The segment map is indexed by {context, va[18+VSEG_W-1:18]}. Virtual bits between that field and bit 29 are ignored. The page map is indexed by {group, va[17:12]}, where group is the segment-map entry.
- R4: On success (cause 0), rsp_pa = {entry[FRAME_W-1:0], va[11:0]}, zero-extended to 32 bits, and rsp_nc = entry bit 28.
- R5: An entry with bit 31 (valid) clear gives cause 2. This check takes priority over all other entry checks.
- R6: A write (req_write=1) to a valid entry with bit 30 (writable) clear gives cause 3. This check takes priority over the privilege check.
- R7: A user access (req_user=1) to a valid entry with bit 29 (supervisor-only) set gives cause 4. A supervisor access ignores bit 29.
- R8: A successful access writes the entry back with bit 25 (used) set. A successful write also sets bit 24 (modified). All other bits are unchanged.
- R9: A faulting access leaves the page entry unchanged and responds with rsp_pa = 0 and rsp_nc = 0.
- R10: The software port uses sw_target to select what it touches:
  - sw_target 0 selects the context register. A write stores sw_wdata[CTX_W-1:0].
  - sw_target 1 selects the segment map. A write stores sw_wdata[GRP_W-1:0], and a read returns it zero-extended.
  - sw_target 2 selects the page map, which holds all 32 bits.
  - sw_target 3 ignores writes and reads back 0.
  Read data appears with sw_rvalid in the cycle after acceptance.
- R11: sw_ready is high only in ST_IDLE. When sw_valid and req_valid are both high in ST_IDLE, the software access is taken and req_ready stays low.
- R12: After reset the block is in ST_IDLE with the context register at 0, req_ready and sw_ready high, and rsp_valid and sw_rvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_cause | output | 3 | 0 none, 1 hole, 2 invalid, 3 write-protect, 4 privilege |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_nc | output | 1 | Access must bypass caches |
| sw_valid | input | 1 | Software map access valid |
| sw_ready | output | 1 | Software access can be taken |
| sw_write | input | 1 | Software access is a write |
| sw_target | input | 2 | 0 context, 1 segment map, 2 page map, 3 none |
| sw_addr | input | SW_AW | Map index for software access |
| sw_wdata | input | 32 | Software write data |
| sw_rvalid | output | 1 | Software read data valid |
| sw_rdata | output | 32 | Software read data |

## Verification
The bench runs a small configuration: four contexts, eight segments per context and eight page groups. Every segment and page of every context is swept with all four write and user combinations, over page entries whose valid, writable, supervisor and non-cacheable bits vary with the index. This separates the fault priorities from one another and from successes, and it exercises the used and modified bits when a page is touched again. The upper address bits alternate between the two legal patterns, and the ignored middle bits change from one access to the next, so that wrong indexing or aliasing shows up as a wrong frame. All six hole patterns and the four boundary addresses around the hole are tried, and a final read of the whole page map separates correct write-back from unwanted updates after faults.

// File: rtl/segmap_xlate_pkg.sv
package segmap_xlate_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_HOLE    = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_WPROT   = 3'd3,
        CAUSE_PRIV    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        TGT_CTX  = 2'd0,
        TGT_SEG  = 2'd1,
        TGT_PAGE = 2'd2,
        TGT_NONE = 2'd3
    } sw_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEG   = 2'd1,
        ST_PAGE  = 2'd2,
        ST_WBACK = 2'd3
    } state_e;

    localparam int BIT_VALID = 31;
    localparam int BIT_WR    = 30;
    localparam int BIT_SUP   = 29;
    localparam int BIT_NC    = 28;
    localparam int BIT_USED  = 25;
    localparam int BIT_MOD   = 24;

    localparam int OFF_W    = 12;
    localparam int VPG_W    = 6;
    localparam int SEG_LSB  = 18;
    localparam int HOLE_LSB = 29;

endpackage

// File: rtl/segmap_xlate_ram.sv
module segmap_xlate_ram #(
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/segmap_xlate_pte_check.sv
module segmap_xlate_pte_check
    import segmap_xlate_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic [31:0]      pte,
    input  logic             is_write,
    input  logic             is_user,
    input  logic [OFF_W-1:0] va_off,
    output cause_e           cause,
    output logic [31:0]      pte_upd,
    output logic [31:0]      pa,
    output logic             nc
);

    logic ok;

    always_comb begin
        cause = CAUSE_NONE;
        if (!pte[BIT_VALID]) begin
            cause = CAUSE_INVALID;
        end else if (is_write && !pte[BIT_WR]) begin
            cause = CAUSE_WPROT;
        end else if (is_user && pte[BIT_SUP]) begin
            cause = CAUSE_PRIV;
        end
        ok = (cause == CAUSE_NONE);

        pte_upd = pte;
        pte_upd[BIT_USED] = 1'b1;
        if (is_write) begin
            pte_upd[BIT_MOD] = 1'b1;
        end

        pa = ok ? 32'({pte[FRAME_W-1:0], va_off}) : 32'd0;
        nc = ok & pte[BIT_NC];
    end

endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate
    import segmap_xlate_pkg::*;
#(
    parameter int CTX_W   = 3,
    parameter int VSEG_W  = 8,
    parameter int GRP_W   = 5,
    parameter int FRAME_W = 16,
    localparam int SEG_AW = CTX_W + VSEG_W,
    localparam int PG_AW  = GRP_W + VPG_W,
    localparam int SW_AW  = (SEG_AW > PG_AW) ? SEG_AW : PG_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_va,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [2:0]       rsp_cause,
    output logic [31:0]      rsp_pa,
    output logic             rsp_nc,
    input  logic             sw_valid,
    output logic             sw_ready,
    input  logic             sw_write,
    input  logic [1:0]       sw_target,
    input  logic [SW_AW-1:0] sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic             sw_rvalid,
    output logic [31:0]      sw_rdata
);

    state_e state_q, state_d;

    logic [CTX_W-1:0]  ctx_q;
    logic [VSEG_W-1:0] va_seg_q;
    logic [VPG_W-1:0]  va_pg_q;
    logic [OFF_W-1:0]  va_off_q;
    logic              wr_q, usr_q;
    sw_tgt_e           sw_tgt_q;

    logic              in_hole, accept, sw_acc;
    logic [31:0]       unused_va;

    logic              smap_en, smap_we;
    logic [SEG_AW-1:0] smap_addr;
    logic [GRP_W-1:0]  smap_wdata, smap_rdata;
    logic              pmap_en, pmap_we;
    logic [PG_AW-1:0]  pmap_addr;
    logic [31:0]       pmap_wdata, pmap_rdata;

    cause_e            chk_cause;
    logic [31:0]       chk_pte_upd, chk_pa;
    logic              chk_nc;

    assign unused_va = req_va;
    assign in_hole   = (req_va[31:HOLE_LSB] != 3'b000) && (req_va[31:HOLE_LSB] != 3'b111);
    assign sw_ready  = (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE) && !sw_valid;
    assign accept    = req_valid && req_ready;
    assign sw_acc    = sw_valid && sw_ready;

    segmap_xlate_ram #(.AW(SEG_AW), .DW(GRP_W)) u_segmap (
        .clk   (clk),
        .en    (smap_en),
        .we    (smap_we),
        .addr  (smap_addr),
        .wdata (smap_wdata),
        .rdata (smap_rdata)
    );

    segmap_xlate_ram #(.AW(PG_AW), .DW(32)) u_pagemap (
        .clk   (clk),
        .en    (pmap_en),
        .we    (pmap_we),
        .addr  (pmap_addr),
        .wdata (pmap_wdata),
        .rdata (pmap_rdata)
    );

    segmap_xlate_pte_check #(.FRAME_W(FRAME_W)) u_check (
        .pte      (pmap_rdata),
        .is_write (wr_q),
        .is_user  (usr_q),
        .va_off   (va_off_q),
        .cause    (chk_cause),
        .pte_upd  (chk_pte_upd),
        .pa       (chk_pa),
        .nc       (chk_nc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && !in_hole) state_d = ST_SEG;
            ST_SEG:   state_d = ST_PAGE;
            ST_PAGE:  state_d = ST_WBACK;
            ST_WBACK: state_d = ST_IDLE;
        endcase
    end

    // map port control per state
    always_comb begin
        smap_en    = 1'b0;
        smap_we    = 1'b0;
        smap_addr  = {ctx_q, va_seg_q};
        smap_wdata = sw_wdata[GRP_W-1:0];
        pmap_en    = 1'b0;
        pmap_we    = 1'b0;
        pmap_addr  = {smap_rdata, va_pg_q};
        pmap_wdata = chk_pte_upd;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_acc && sw_target == TGT_SEG) begin
                    smap_en   = 1'b1;
                    smap_we   = sw_write;
                    smap_addr = sw_addr[SEG_AW-1:0];
                end
                if (sw_acc && sw_target == TGT_PAGE) begin
                    pmap_en    = 1'b1;
                    pmap_we    = sw_write;
                    pmap_addr  = sw_addr[PG_AW-1:0];
                    pmap_wdata = sw_wdata;
                end
            end
            ST_SEG:  smap_en = 1'b1;
            ST_PAGE: pmap_en = 1'b1;
            ST_WBACK: begin
                pmap_en = (chk_cause == CAUSE_NONE);
                pmap_we = 1'b1;
            end
        endcase
    end

    // registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_pa    <= '0;
            rsp_nc    <= 1'b0;
            sw_rvalid <= 1'b0;
            sw_tgt_q  <= TGT_NONE;
            va_seg_q  <= '0;
            va_pg_q   <= '0;
            va_off_q  <= '0;
            wr_q      <= 1'b0;
            usr_q     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            sw_rvalid <= sw_acc && !sw_write;
            if (sw_acc) begin
                sw_tgt_q <= sw_tgt_e'(sw_target);
                if (sw_write && sw_target == TGT_CTX) begin
                    ctx_q <= sw_wdata[CTX_W-1:0];
                end
            end
            if (accept) begin
                va_seg_q <= req_va[SEG_LSB +: VSEG_W];
                va_pg_q  <= req_va[OFF_W +: VPG_W];
                va_off_q <= req_va[OFF_W-1:0];
                wr_q     <= req_write;
                usr_q    <= req_user;
                if (in_hole) begin
                    rsp_valid <= 1'b1;
                    rsp_cause <= CAUSE_HOLE;
                    rsp_pa    <= '0;
                    rsp_nc    <= 1'b0;
                end
            end
            if (state_q == ST_WBACK) begin
                rsp_valid <= 1'b1;
                rsp_cause <= chk_cause;
                rsp_pa    <= chk_pa;
                rsp_nc    <= chk_nc;
            end
        end
    end

    always_comb begin
        unique case (sw_tgt_q)
            TGT_CTX:  sw_rdata = 32'(ctx_q);
            TGT_SEG:  sw_rdata = 32'(smap_rdata);
            TGT_PAGE: sw_rdata = pmap_rdata;
            TGT_NONE: sw_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/segmap_xlate_chk.sv
module segmap_xlate_chk #(
    parameter int CTX_W   = 3,
    parameter int VSEG_W  = 8,
    parameter int GRP_W   = 5,
    parameter int FRAME_W = 16,
    localparam int SEG_AW = CTX_W + VSEG_W,
    localparam int PG_AW  = GRP_W + 6,
    localparam int SW_AW  = (SEG_AW > PG_AW) ? SEG_AW : PG_AW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_va,
    input logic             req_write,
    input logic             req_user,
    input logic             rsp_valid,
    input logic [2:0]       rsp_cause,
    input logic [31:0]      rsp_pa,
    input logic             rsp_nc,
    input logic             sw_valid,
    input logic             sw_ready,
    input logic             sw_write,
    input logic [1:0]       sw_target,
    input logic [SW_AW-1:0] sw_addr,
    input logic [31:0]      sw_wdata,
    input logic             sw_rvalid,
    input logic [31:0]      sw_rdata
);

    logic hole;
    assign hole = (req_va[31:29] != 3'b000) && (req_va[31:29] != 3'b111);

    // R1
    hole_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hole) |=> (rsp_valid && rsp_cause == 3'd1 && rsp_pa == 32'd0 && !rsp_nc));

    // R2
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hole) |=> (!req_ready && !rsp_valid) ##1 (!req_ready && !rsp_valid)
                                           ##1 (!req_ready && !rsp_valid) ##1 (rsp_valid && sw_ready));

    // R4
    pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 3'd0) |-> (rsp_pa[11:0] == $past(req_va[11:0], 4)));

    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 3'd0) |-> (rsp_pa == 32'd0 && !rsp_nc));

    // R10
    sw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_ready && !sw_write) |=> sw_rvalid);

    // R11
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_valid && sw_ready && req_valid && req_ready));

endmodule

bind segmap_xlate segmap_xlate_chk #(
    .CTX_W   (CTX_W),
    .VSEG_W  (VSEG_W),
    .GRP_W   (GRP_W),
    .FRAME_W (FRAME_W)
) u_chk (.*);

// File: tb/segmap_xlate_bench.sv
module segmap_xlate_bench;

    localparam int CTX_W   = 2;
    localparam int VSEG_W  = 3;
    localparam int GRP_W   = 3;
    localparam int FRAME_W = 16;
    localparam int SEG_N   = 1 << (CTX_W + VSEG_W);
    localparam int PG_N    = 1 << (GRP_W + 6);
    localparam int SW_AW   = GRP_W + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic req_ready, rsp_valid, rsp_nc;
    logic [2:0] rsp_cause;
    logic [31:0] rsp_pa;
    logic sw_valid = 1'b0, sw_write = 1'b0;
    logic [1:0] sw_target = '0;
    logic [SW_AW-1:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic sw_ready, sw_rvalid;
    logic [31:0] sw_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [GRP_W-1:0] smodel [SEG_N];
    logic [31:0]      pmodel [PG_N];
    logic [CTX_W-1:0] cur_ctx = '0;

    always #5 clk = ~clk;

    segmap_xlate #(.CTX_W(CTX_W), .VSEG_W(VSEG_W), .GRP_W(GRP_W), .FRAME_W(FRAME_W)) u_segmap_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_pa(rsp_pa), .rsp_nc(rsp_nc),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_write(sw_write), .sw_target(sw_target),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rvalid(sw_rvalid), .sw_rdata(sw_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic logic [31:0] gen_pte(input int i);
        logic [31:0] p;
        logic [15:0] fr;
        fr = 16'(i * 40503 + 7);
        p = '0;
        p[31] = (i % 5) != 0;
        p[30] = (i % 3) != 0;
        p[29] = i[2] ^ i[4];
        p[28] = i[3];
        p[27:26] = 2'(i >> 5);
        p[25] = i[7];
        p[18:0] = {3'(i), fr};
        return p;
    endfunction

    task automatic sw_op(input logic [1:0] tgt, input logic wr, input int addr,
                         input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        sw_valid = 1'b1; sw_write = wr; sw_target = tgt;
        sw_addr = SW_AW'(addr); sw_wdata = wd;
        @(posedge clk);
        #1;
        sw_valid = 1'b0;
        rd = sw_rdata;
        if (!wr) chk("R10 rvalid", 64'(sw_rvalid), 64'd1);
    endtask

    task automatic set_ctx(input int c);
        logic [31:0] d;
        sw_op(2'd0, 1'b1, 0, 32'(c), d);
        cur_ctx = CTX_W'(c);
    endtask

    task automatic xlate(input logic [31:0] va, input logic wr, input logic usr);
        logic [2:0] ecause;
        logic [31:0] epa, p;
        logic enc;
        int sidx, pidx, lat, elat;
        logic busy_ok;
        string tag;
        sidx = int'({cur_ctx, va[20:18]});
        pidx = int'({smodel[sidx], va[17:12]});
        p = pmodel[pidx];
        epa = 32'd0;
        enc = 1'b0;
        if (va[31:29] != 3'b000 && va[31:29] != 3'b111) begin ecause = 3'd1; tag = "R1"; end
        else if (!p[31]) begin ecause = 3'd2; tag = "R5 R9"; end
        else if (wr && !p[30]) begin ecause = 3'd3; tag = "R6 R9"; end
        else if (usr && p[29]) begin ecause = 3'd4; tag = "R7 R9"; end
        else begin
            ecause = 3'd0;
            tag = "R3 R4";
            epa = {4'd0, p[15:0], va[11:0]};
            enc = p[28];
            p[25] = 1'b1;
            if (wr) p[24] = 1'b1;
            pmodel[pidx] = p;
        end
        elat = (ecause == 3'd1) ? 1 : 4;
        @(negedge clk);
        req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        lat = 0;
        busy_ok = 1'b1;
        while (lat < 8) begin
            @(negedge clk);
            lat++;
            if (rsp_valid) break;
            if (req_ready) busy_ok = 1'b0;
        end
        chk(ecause == 3'd1 ? "R1 latency" : "R2 latency", 64'(lat), 64'(elat));
        if (ecause != 3'd1) chk("R2 busy", 64'(busy_ok), 64'd1);
        chk(tag, {29'd0, rsp_cause, rsp_nc, rsp_pa}, {29'd0, ecause, enc, epa});
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        chk("R12 ready", {60'd0, req_ready, sw_ready, rsp_valid, sw_rvalid}, 64'b1100);
        sw_op(2'd0, 1'b0, 0, 32'd0, rd);
        chk("R12 ctx", 64'(rd), 64'd0);

        for (int i = 0; i < SEG_N; i++) begin
            smodel[i] = GRP_W'(i * 5 + 3);
            sw_op(2'd1, 1'b1, i, 32'(smodel[i]) | 32'hFFFF_FF00, rd);
        end
        for (int i = 0; i < PG_N; i++) begin
            pmodel[i] = gen_pte(i);
            sw_op(2'd2, 1'b1, i, pmodel[i], rd);
        end

        // R10 software port
        sw_op(2'd1, 1'b0, 9, 32'd0, rd);
        chk("R10 segmap read", 64'(rd), 64'(smodel[9]));
        sw_op(2'd1, 1'b1, 9, 32'hFFFF_FFFF, rd);
        sw_op(2'd1, 1'b0, 9, 32'd0, rd);
        chk("R10 segmap width", 64'(rd), 64'd7);
        sw_op(2'd1, 1'b1, 9, 32'(smodel[9]), rd);
        sw_op(2'd2, 1'b0, 100, 32'd0, rd);
        chk("R10 pagemap read", 64'(rd), 64'(pmodel[100]));
        sw_op(2'd0, 1'b1, 0, 32'hFFFF_FFFD, rd);
        sw_op(2'd0, 1'b0, 0, 32'd0, rd);
        chk("R10 ctx width", 64'(rd), 64'd1);
        sw_op(2'd3, 1'b1, 0, 32'hDEAD_BEEF, rd);
        sw_op(2'd3, 1'b0, 0, 32'd0, rd);
        chk("R10 target3 read", 64'(rd), 64'd0);
        sw_op(2'd0, 1'b0, 0, 32'd0, rd);
        chk("R10 target3 no effect", 64'(rd), 64'd1);
        set_ctx(0);

        // R11 software priority
        @(negedge clk);
        sw_valid = 1'b1; sw_write = 1'b0; sw_target = 2'd0;
        req_valid = 1'b1; req_va = 32'h0000_1000;
        #1;
        chk("R11 req_ready low", {62'd0, req_ready, sw_ready}, 64'b01);
        @(posedge clk);
        #1;
        sw_valid = 1'b0; req_valid = 1'b0;
        begin
            int seen = 0;
            repeat (5) begin
                @(negedge clk);
                if (rsp_valid) seen++;
            end
            chk("R11 no translation", 64'(seen), 64'd0);
        end

        // R1 hole sweep and boundaries
        for (int t = 1; t < 7; t++) begin
            for (int k = 0; k < 4; k++) begin
                xlate({3'(t), 29'(k * 32'h0123_4567)}, k[0], k[1]);
            end
        end
        xlate(32'h2000_0000, 1'b0, 1'b0);
        xlate(32'hDFFF_FFFF, 1'b0, 1'b0);
        xlate(32'h1FFF_FFFF, 1'b0, 1'b0);
        xlate(32'hE000_0000, 1'b0, 1'b0);

        // R3..R9 full sweep
        for (int c = 0; c < 4; c++) begin
            set_ctx(c);
            for (int s = 0; s < 8; s++) begin
                for (int pg = 0; pg < 64; pg++) begin
                    for (int m = 0; m < 4; m++) begin
                        logic [31:0] va;
                        va[31:29] = ((s ^ pg) & 1) != 0 ? 3'b111 : 3'b000;
                        va[28:21] = 8'(pg * 3 + c + m * 17);
                        va[20:18] = 3'(s);
                        va[17:12] = 6'(pg);
                        va[11:0]  = 12'(pg * 61 + s * 7 + m);
                        xlate(va, m[0], m[1]);
                    end
                end
            end
        end

        // R3 explicit context separation
        smodel[{2'd1, 3'd3}] = 3'd2;
        sw_op(2'd1, 1'b1, {2'd1, 3'd3}, 32'd2, rd);
        smodel[{2'd2, 3'd3}] = 3'd6;
        sw_op(2'd1, 1'b1, {2'd2, 3'd3}, 32'd6, rd);
        pmodel[2 * 64 + 5] = 32'h8000_1234;
        sw_op(2'd2, 1'b1, 2 * 64 + 5, pmodel[2 * 64 + 5], rd);
        pmodel[6 * 64 + 5] = 32'hC000_BEEF;
        sw_op(2'd2, 1'b1, 6 * 64 + 5, pmodel[6 * 64 + 5], rd);
        set_ctx(1);
        xlate(32'h00CC_5ABC, 1'b0, 1'b1);
        chk("R3 ctx1 frame", 64'(rsp_pa), 64'h0123_4ABC);
        set_ctx(2);
        xlate(32'hFFEC_5ABC, 1'b1, 1'b1);
        chk("R3 ctx2 frame", 64'(rsp_pa), 64'h0BEE_FABC);

        // R8 write-back, R9 untouched on fault
        for (int i = 0; i < PG_N; i++) begin
            sw_op(2'd2, 1'b0, i, 32'd0, rd);
            chk("R8 R9 readback", 64'(rd), 64'(pmodel[i]));
        end
        finish_run();
    end

endmodule